// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller sits between nineteen peripheral interrupt requests and a small 8-bit processor core. Each source has a pending flag, an enable bit and a level bit that chooses low or high priority. Every cycle the controller picks the eligible request that should be served next. It registers that choice and offers the core a vector address with a valid strobe.

The core accepts the offered vector by raising `vec_ack` while `vec_valid` is high. The valid/ready rules are as follows. The vector counts as taken only on a clock edge where both signals are high. While `vec_ack` stays low, the offer remains up but may be replaced by a better request that has become eligible in the meantime. An `vec_ack` with no offer pending has no effect. Taking a vector records its level as in service. A `reti` pulse from the core retires the most recent level.

Source n vectors to 0x0003 + 8·n. Address 0x0000 is reserved for reset, which is handled outside this block and ranks above everything. Sources 0 to 3 have their flags cleared by hardware when taken. All other flags stay set until software writes them. Source 15 (supply warning) shows a live, read-only status input as its flag, so only its enable bit stops repeated vectoring. Source 16 (port match) has no flag at all: its request is the live match input. Software reaches the enable, level, pending and global-enable state through a plain register write/read port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the enable, level, pending and global-enable registers read as zero, no level is in service, and `vec_valid` is low.
- R2: When `vec_valid` is high, `vec_addr` equals 3 + 8·n for the offered source n (0x0003 for source 0, 0x0093 for source 18).
- R3: A source is eligible only when its flag, its enable bit and the global enable (bit 0 at register address 3) are all set. The offer appears on the second clock edge after the last of these becomes true.
- R4: Among eligible sources, any high-level source (level bit = 1) beats all low-level ones. Within the same level the lower source number wins.
- R5: With nothing in service any level may be offered. While a low level is in service only high-level sources are offered. While a high level is in service nothing is offered.
- R6: On an edge where `vec_valid` and `vec_ack` are both high, the vector is taken and `vec_valid` is low for the following cycle. An `vec_ack` while `vec_valid` is low changes nothing.
- R7: Taking the vector of source 0, 1, 2 or 3 clears that source's flag. Taking any other source leaves its flag set.
- R8: A write to address 2 loads the flags of sources other than 15 and 16 from `reg_wdata`. A hardware set request (`irq_set`) in the same cycle wins over both that write and the hardware clear.
- R9: Flag 15 always reads as the live `warn_live` input, and writes to address 2 do not change it. Clearing enable bit 15 is what stops its vectoring.
- R10: Source 16 has no stored flag. Its bit at address 2 reads as the live `match_live` input, and its request is that input gated by its enable.
- R11: A `reti` pulse clears the high in-service level if it is set and otherwise clears the low level. Any request blocked by that level is then offered again.
- R12: `reg_rdata` shows, for the current `reg_addr`: enable bits at address 0, level bits at address 1, flag view at address 2, and the global enable in bit 0 at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_set | input | 19 | Per-source hardware set request (peripheral flags already ORed) |
| warn_live | input | 1 | Live supply-warning status (source 15 flag) |
| match_live | input | 1 | Live port-match condition (source 16 request) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 enable, 1 level, 2 pending, 3 global enable |
| reg_wdata | input | 19 | Register write data |
| reg_rdata | output | 19 | Register read data for `reg_addr` |
| vec_valid | output | 1 | Vector offered to the core |
| vec_addr | output | 16 | Offered vector address |
| vec_ack | input | 1 | Core accepts the offered vector |
| reti | input | 1 | Return-from-interrupt pulse |

## Verification
The embedded properties assume that the core pulses `reti` only while at least one level is in service. They also assume that `reti` never coincides with a taken vector, since the in-service record then obeys the take and drops the return. The stimulus tracks the in-service state in its reference model and issues `reti` only when that model shows an active level and no accepted offer in the same cycle. `vec_ack` is driven freely, including with no offer pending, because the controller must ignore it then.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam logic [1:0] RA_ENABLE = 2'd0;
  localparam logic [1:0] RA_LEVEL  = 2'd1;
  localparam logic [1:0] RA_FLAGS  = 2'd2;
  localparam logic [1:0] RA_GLOBAL = 2'd3;

  typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} irq_lvl_e;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC     = 19,
  parameter int N_AUTOCLR = 4,
  parameter int WARN_IDX  = 15,
  parameter int MATCH_IDX = 16,
  localparam int IDX_W    = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic             warn_i,
  input  logic             match_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] take_idx_i,
  output logic [N_SRC-1:0] level_o,
  output logic [N_SRC-1:0] req_o,
  output logic [N_SRC-1:0] rdata_o
);
  logic [N_SRC-1:0] enable_q, level_q, flag_view;
  logic             global_q;
  logic             wr_flags;

  assign wr_flags = wr_i && (addr_i == RA_FLAGS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      level_q  <= '0;
      global_q <= 1'b0;
    end else if (wr_i) begin
      case (addr_i)
        RA_ENABLE: enable_q <= wdata_i;
        RA_LEVEL:  level_q  <= wdata_i;
        RA_GLOBAL: global_q <= wdata_i[0];
        default:   ;
      endcase
    end
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    if (n == WARN_IDX) begin : g_warn
      assign flag_view[n] = warn_i;
    end else if (n == MATCH_IDX) begin : g_match
      assign flag_view[n] = match_i;
    end else begin : g_flag
      localparam bit AUTO = (n < N_AUTOCLR);
      logic flag_q;
      logic hw_clr;
      assign hw_clr = AUTO && take_i && (take_idx_i == IDX_W'(n));
      always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= set_i[n] | (wr_flags ? wdata_i[n] : (flag_q & ~hw_clr));
      end
      assign flag_view[n] = flag_q;
      if (AUTO) begin : g_chk
        assert_autoclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
          (take_i && take_idx_i == IDX_W'(n) && !set_i[n] && !wr_flags) |=> !flag_q);
      end
    end
  end

  assign req_o   = flag_view & enable_q & {N_SRC{global_q}};
  assign level_o = level_q;

  always_comb begin
    case (addr_i)
      RA_ENABLE: rdata_o = enable_q;
      RA_LEVEL:  rdata_o = level_q;
      RA_FLAGS:  rdata_o = flag_view;
      default:   rdata_o = {{(N_SRC-1){1'b0}}, global_q};
    endcase
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 19,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] level_i,
  input  logic             ins_low_i,
  input  logic             ins_high_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o,
  output irq_lvl_e         lvl_o
);
  logic [N_SRC-1:0] hi_req, lo_req;
  logic             hi_any, lo_any;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  assign hi_req = req_i & level_i;
  assign lo_req = req_i & ~level_i;

  always_comb begin
    hi_any = 1'b0; hi_idx = '0;
    lo_any = 1'b0; lo_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (hi_req[i]) begin hi_any = 1'b1; hi_idx = IDX_W'(i); end
      if (lo_req[i]) begin lo_any = 1'b1; lo_idx = IDX_W'(i); end
    end
  end

  always_comb begin
    found_o = 1'b0;
    idx_o   = hi_idx;
    lvl_o   = LVL_HIGH;
    if (!ins_high_i) begin
      if (hi_any) begin
        found_o = 1'b1;
      end else if (lo_any && !ins_low_i) begin
        found_o = 1'b1;
        idx_o   = lo_idx;
        lvl_o   = LVL_LOW;
      end
    end
  end
endmodule

// File: rtl/irq_nest.sv
module irq_nest
  import irq_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take_i,
  input  irq_lvl_e take_lvl_i,
  input  logic     reti_i,
  output logic     ins_low_o,
  output logic     ins_high_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_low_o  <= 1'b0;
      ins_high_o <= 1'b0;
    end else if (take_i) begin
      if (take_lvl_i == LVL_HIGH) ins_high_o <= 1'b1;
      else                        ins_low_o  <= 1'b1;
    end else if (reti_i) begin
      if (ins_high_o) ins_high_o <= 1'b0;
      else            ins_low_o  <= 1'b0;
    end
  end

  assert_reti_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !take_i && ins_high_o) |=> (!ins_high_o && ins_low_o == $past(ins_low_o)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC      = 19,
  parameter int N_AUTOCLR  = 4,
  parameter int WARN_IDX   = 15,
  parameter int MATCH_IDX  = 16,
  parameter int ADDR_W     = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W     = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_set,
  input  logic              warn_live,
  input  logic              match_live,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [N_SRC-1:0]  reg_wdata,
  output logic [N_SRC-1:0]  reg_rdata,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr,
  input  logic              vec_ack,
  input  logic              reti
);
  logic [N_SRC-1:0] req, level;
  logic             ins_low, ins_high;
  logic             found;
  logic [IDX_W-1:0] pick_idx, vec_idx_q;
  irq_lvl_e         pick_lvl, vec_lvl_q;
  logic             vec_valid_q;
  logic             take;

  assign take = vec_valid_q && vec_ack;

  irq_src_regs #(
    .N_SRC(N_SRC), .N_AUTOCLR(N_AUTOCLR), .WARN_IDX(WARN_IDX), .MATCH_IDX(MATCH_IDX)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .set_i(irq_set), .warn_i(warn_live), .match_i(match_live),
    .wr_i(reg_wr), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .take_i(take), .take_idx_i(vec_idx_q),
    .level_o(level), .req_o(req), .rdata_o(reg_rdata)
  );

  irq_pick #(.N_SRC(N_SRC)) u_pick (
    .req_i(req), .level_i(level), .ins_low_i(ins_low), .ins_high_i(ins_high),
    .found_o(found), .idx_o(pick_idx), .lvl_o(pick_lvl)
  );

  irq_nest u_nest (
    .clk(clk), .rst_n(rst_n), .take_i(take), .take_lvl_i(vec_lvl_q), .reti_i(reti),
    .ins_low_o(ins_low), .ins_high_o(ins_high)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid_q <= 1'b0;
      vec_idx_q   <= '0;
      vec_lvl_q   <= LVL_LOW;
    end else begin
      vec_valid_q <= take ? 1'b0 : found;
      if (found) begin
        vec_idx_q <= pick_idx;
        vec_lvl_q <= pick_lvl;
      end
    end
  end

  assign vec_valid = vec_valid_q;
  assign vec_addr  = ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(vec_idx_q);

  assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_addr[2:0] == 3'b011 &&
                   vec_addr <= ADDR_W'(VEC_BASE + VEC_STRIDE * (N_SRC - 1))));
  assert_take_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ack) |=> !vec_valid);
  assert_high_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !ins_high);
  assert_low_only_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && ins_low) |-> (vec_lvl_q == LVL_HIGH));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  localparam int N = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_set = '0;
  logic          warn_live = 1'b0, match_live = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [N-1:0]  reg_wdata = '0;
  logic [N-1:0]  reg_rdata;
  logic          vec_valid;
  logic [15:0]   vec_addr;
  logic          vec_ack = 1'b0, reti = 1'b0;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_set(irq_set), .warn_live(warn_live),
    .match_live(match_live), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .vec_ack(vec_ack), .reti(reti)
  );

  // behavioural reference state
  bit m_pend[N], m_en[N], m_pri[N];
  bit m_gen, m_lo, m_hi, m_vv, m_vhi;
  int m_vidx;

  function automatic bit m_view(int n);
    if (n == 15) return warn_live;
    if (n == 16) return match_live;
    return m_pend[n];
  endfunction

  function automatic logic [N-1:0] m_read(logic [1:0] a);
    logic [N-1:0] r = '0;
    for (int n = 0; n < N; n++) begin
      case (a)
        2'd0: r[n] = m_en[n];
        2'd1: r[n] = m_pri[n];
        2'd2: r[n] = m_view(n);
        default: r[n] = (n == 0) ? m_gen : 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit f = 0, fhi = 0;
    int fidx = 0;
    bit fire;
    if (!m_hi) begin
      for (int n = N - 1; n >= 0; n--)
        if (m_view(n) && m_en[n] && m_gen && m_pri[n]) begin f = 1; fhi = 1; fidx = n; end
      if (!f && !m_lo)
        for (int n = N - 1; n >= 0; n--)
          if (m_view(n) && m_en[n] && m_gen && !m_pri[n]) begin f = 1; fhi = 0; fidx = n; end
    end
    fire = m_vv && vec_ack;
    for (int n = 0; n < N; n++) begin
      if (n == 15 || n == 16) continue;
      if (reg_wr && reg_addr == 2'd2) m_pend[n] = reg_wdata[n];
      else if (fire && m_vidx == n && n < 4) m_pend[n] = 0;
      if (irq_set[n]) m_pend[n] = 1;
    end
    if (reg_wr) begin
      for (int n = 0; n < N; n++) begin
        if (reg_addr == 2'd0) m_en[n] = reg_wdata[n];
        if (reg_addr == 2'd1) m_pri[n] = reg_wdata[n];
      end
      if (reg_addr == 2'd3) m_gen = reg_wdata[0];
    end
    if (fire) begin
      if (m_vhi) m_hi = 1; else m_lo = 1;
    end else if (reti) begin
      if (m_hi) m_hi = 0; else m_lo = 0;
    end
    m_vv = fire ? 0 : f;
    if (f) begin m_vidx = fidx; m_vhi = fhi; end
  endtask

  // one clock: model follows the edge, outputs compared 2 ns later
  task automatic step();
    @(posedge clk);
    if (rst_n) model_edge();
    #2;
    check(vec_valid === m_vv, "R3/R4/R5/R6 vec_valid", int'(vec_valid), int'(m_vv));
    if (m_vv)
      check(vec_addr === 16'(3 + 8 * m_vidx), "R2/R4 vec_addr", int'(vec_addr), 3 + 8 * m_vidx);
    check(reg_rdata === m_read(reg_addr), "R12 reg_rdata", int'(reg_rdata), int'(m_read(reg_addr)));
    irq_set = '0; reg_wr = 0; vec_ack = 0; reti = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; step();
  endtask

  task automatic rd_bit(logic [1:0] a, int b, bit exp, string tag);
    reg_addr = a; #1;
    check(reg_rdata[b] === exp, tag, int'(reg_rdata[b]), int'(exp));
  endtask

  task automatic expect_vec(bit v, int adr, string tag);
    check(vec_valid === v, tag, int'(vec_valid), int'(v));
    if (v) check(vec_addr === 16'(adr), tag, int'(vec_addr), adr);
  endtask

  task automatic ack();
    vec_ack = 1; step();
  endtask

  task automatic do_reti();
    reti = 1; step();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    #1;
    // R1: reset state
    expect_vec(0, 0, "R1 reset vec_valid");
    for (int a = 0; a < 4; a++) begin
      reg_addr = 2'(a); #1;
      check(reg_rdata === '0, "R1 reset register", int'(reg_rdata), 0);
    end
    step();

    // R3: enabled but global enable off
    wr(2'd0, '1);
    irq_set[0] = 1; step(); step(); step();
    expect_vec(0, 0, "R3 no offer without global enable");
    wr(2'd3, 19'd1); step();
    expect_vec(1, 16'h0003, "R3 R2 source 0 offered");

    // R6: ack taken, drops; R7: auto clear source 0
    ack();
    expect_vec(0, 0, "R6 drop after take");
    rd_bit(2'd2, 0, 0, "R7 source 0 auto cleared");
    do_reti(); step();

    // R4 low order, R7 no auto clear on 5
    irq_set[5] = 1; irq_set[9] = 1; step(); step();
    expect_vec(1, 16'h002B, "R4 lower number wins");
    ack();
    rd_bit(2'd2, 5, 1, "R7 source 5 stays pending");
    step(); step();
    expect_vec(0, 0, "R5 same level waits");
    // raise source 9 to high: preempts low
    wr(2'd1, 19'h00200); step();
    expect_vec(1, 16'h004B, "R5 high preempts low");
    ack(); step(); step();
    expect_vec(0, 0, "R5 nothing during high");
    // R11: first reti retires high; source 9 re-offered (still pending, high)
    do_reti(); step();
    expect_vec(1, 16'h004B, "R11 high retired, 9 offered again");
    wr(2'd2, 19'h00020); step();
    rd_bit(2'd2, 9, 0, "R8 software cleared flag 9");
    expect_vec(0, 0, "R5 low still in service");
    do_reti(); step();
    expect_vec(1, 16'h002B, "R11 low retired, 5 offered");
    // R8: set wins over software clear
    irq_set[5] = 1; reg_wr = 1; reg_addr = 2'd2; reg_wdata = '0; step();
    rd_bit(2'd2, 5, 1, "R8 set wins over write");
    wr(2'd2, '0); step(); step();
    expect_vec(0, 0, "R8 flags cleared");

    // R9: warning source
    warn_live = 1; step(); step();
    expect_vec(1, 16'h007B, "R9 warning vector");
    wr(2'd2, '0);
    rd_bit(2'd2, 15, 1, "R9 flag 15 not writable");
    wr(2'd0, 19'h77FFF); step();
    expect_vec(0, 0, "R9 enable stops warning");
    warn_live = 0; wr(2'd0, '1);

    // R10: match source
    match_live = 1; step(); step();
    expect_vec(1, 16'h0083, "R10 match vector");
    rd_bit(2'd2, 16, 1, "R10 live match read");
    match_live = 0; step(); step();
    expect_vec(0, 0, "R10 match gone");
    vec_ack = 1; step();
    expect_vec(0, 0, "R6 ack without offer ignored");

    // R2 upper end
    irq_set[18] = 1; step(); step();
    expect_vec(1, 16'h0093, "R2 last vector");
    ack(); do_reti(); wr(2'd2, '0); step();

    // random phase, checked against model every clock
    for (int c = 0; c < 3000; c++) begin
      for (int n = 0; n < N; n++) irq_set[n] = ($urandom_range(0, 29) == 0);
      warn_live  = ($urandom_range(0, 9) == 0) ? ~warn_live : warn_live;
      match_live = ($urandom_range(0, 9) == 0) ? ~match_live : match_live;
      reg_addr = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 19) == 0) begin
        reg_wr = 1;
        reg_wdata = (reg_addr == 2'd3) ? 19'(($urandom_range(0, 3) != 0)) : 19'($urandom);
      end
      vec_ack = ($urandom_range(0, 2) == 0);
      if ((m_lo || m_hi) && !(vec_ack && m_vv) && $urandom_range(0, 5) == 0) reti = 1;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule